// File: doc/BRIEF.md
# Modem Line Change Detector

This block watches the four modem-status inputs of a serial port: clear-to-send, carrier detect, ring indicator and data-set-ready. Each input passes through a multi-flop synchronizer. Software can read the settled levels at any time. For clear-to-send and carrier detect the block also records line changes. Each of these two lines has its own tracker. The tracker can report every edge, or only rising edges, or only falling edges. It latches the event while its enable bit is set. A read of the line register clears the latched events. A summary flag, `line_chg_o`, goes to the interrupt controller while any enabled event is pending.

The same small register port also drives the two modem-control outputs. The ready-to-send and data-terminal-ready pins carry the inverse of the bits software writes. A loopback control bit is held here as well and passed on to the serial datapath.

Each change tracker is a two-state machine. In state CHG_IDLE no event is held. In state CHG_PENDING an event is held. Transition DETECT goes from CHG_IDLE to CHG_PENDING when a qualifying edge is seen. Transition ACK goes from CHG_PENDING to CHG_IDLE on a clearing read with no qualifying edge in the same cycle. Transition HOLD keeps CHG_PENDING when nothing clears it, or when an edge arrives together with the clearing read.

Top module: `modem_line_watch`

## Requirements
- R1: Register address 0 returns the synchronized input levels: bit 0 clear-to-send, bit 1 carrier detect, bit 2 ring indicator, bit 3 data-set-ready. A pin change appears in these bits after two rising clock edges.
- R2: In all-edges mode, a rising or a falling edge of a watched line sets its change bit. The clear-to-send change bit is address 0 bit 4; the carrier-detect change bit is address 0 bit 5. The enable for channel i is address 1 bit i, and all-edges mode for channel i is address 1 bit 2+i (channel 0 is clear-to-send, channel 1 is carrier detect).
- R3: While a channel's enable bit is 0, no edge on its line sets its change bit.
- R4: When all-edges mode is off, only one polarity sets the change bit. Address 1 bit 4+i set to 1 selects rising edges; set to 0 it selects falling edges.
- R5: A read of address 0 clears both change bits at the clock edge that ends the read.
- R6: If a qualifying edge is seen in the same cycle as a clearing read, that channel's change bit stays set.
- R7: `line_chg_o` is high exactly when some change bit is set and that channel's enable bit is 1. Clearing the enable bit drops the flag without clearing the change bit.
- R8: Address 2 bit 0 drives `rts_n_o` inverted, and bit 1 drives `dtr_n_o` inverted.
- R9: Address 2 bit 2 is the loopback control. It drives `loop_en_o` and reads back.
- R10: Address 1 bits 5:0 read back as last written. Address 3 reads as zero.
- R11: After reset all register bits are 0, `rts_n_o` and `dtr_n_o` are 1, and `loop_en_o` and `line_chg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of address 0 clears the change bits |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| cts_i | input | 1 | Raw clear-to-send pin |
| dcd_i | input | 1 | Raw carrier-detect pin |
| ri_i | input | 1 | Raw ring-indicator pin |
| dsr_i | input | 1 | Raw data-set-ready pin |
| rts_n_o | output | 1 | Ready-to-send pin, inverse of its register bit |
| dtr_n_o | output | 1 | Data-terminal-ready pin, inverse of its register bit |
| loop_en_o | output | 1 | Loopback control to the serial datapath |
| line_chg_o | output | 1 | Summary flag: an enabled change is pending |

## Verification
A qualifying line edge and a clearing read of the line register can land on the same clock edge. Only the transition chosen between ACK and HOLD decides whether the event survives. The bench provokes this by changing a pin exactly two cycles before it issues the read, so that the synchronized edge meets the read strobe. It then checks that the change bit still reads 1 on the next cycle. Random pin toggling mixed with random reads also produces many such collisions. Every cycle is compared against a cycle model kept in the bench.

// File: rtl/mlw_pkg.sv
package mlw_pkg;

    localparam int LINE_CNT  = 4;
    localparam int WATCH_CNT = 2;

    localparam int IDX_CTS = 0;
    localparam int IDX_DCD = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DSR = 3;

    // sense register field bases (channel index added)
    localparam int SENSE_EN_LSB   = 0;
    localparam int SENSE_ALL_LSB  = 2;
    localparam int SENSE_RISE_LSB = 4;
    localparam int SENSE_W        = 6;

    // drive register fields
    localparam int DRV_RTS  = 0;
    localparam int DRV_DTR  = 1;
    localparam int DRV_LOOP = 2;
    localparam int DRV_W    = 3;

    // line register: change bits follow the levels
    localparam int LINE_CHG_LSB = LINE_CNT;

    typedef enum logic [1:0] {
        SEL_LINES = 2'd0,
        SEL_SENSE = 2'd1,
        SEL_DRIVE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CHG_IDLE    = 1'b0,
        CHG_PENDING = 1'b1
    } chg_state_e;

endpackage

// File: rtl/mlw_sync.sv
module mlw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/mlw_chg_track.sv
module mlw_chg_track
    import mlw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic watch_en,
    input  logic all_edges,
    input  logic rise_only,
    input  logic clr,
    output logic qualify,
    output logic pending
);

    chg_state_e state_q, state_d;
    logic       lvl_prev;
    logic       rise, fall, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl;
    end

    always_comb begin
        rise = lvl & ~lvl_prev;
        fall = ~lvl & lvl_prev;
        if (all_edges)      hit = rise | fall;
        else if (rise_only) hit = rise;
        else                hit = fall;
        qualify = watch_en & hit;
    end

    // next state: DETECT, ACK, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHG_IDLE:    if (qualify) state_d = CHG_PENDING;
            CHG_PENDING: if (clr && !qualify) state_d = CHG_IDLE;
            default:     state_d = CHG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CHG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == CHG_PENDING);
    end

endmodule

// File: rtl/mlw_regs.sv
module mlw_regs
    import mlw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [1:0]           addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [LINE_CNT-1:0]  levels,
    input  logic [WATCH_CNT-1:0] pend,
    output logic [DATA_W-1:0]    rdata,
    output logic [WATCH_CNT-1:0] watch_en,
    output logic [WATCH_CNT-1:0] all_edges,
    output logic [WATCH_CNT-1:0] rise_only,
    output logic                 rts_bit,
    output logic                 dtr_bit,
    output logic                 loop_bit
);

    logic [SENSE_W-1:0] sense_q;
    logic [DRV_W-1:0]   drive_q;
    reg_sel_e           sel;
    logic               unused_wdata;

    assign sel          = reg_sel_e'(addr);
    assign unused_wdata = ^wdata[DATA_W-1:SENSE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            drive_q <= '0;
        end else if (wr) begin
            if (sel == SEL_SENSE) sense_q <= wdata[SENSE_W-1:0];
            if (sel == SEL_DRIVE) drive_q <= wdata[DRV_W-1:0];
        end
    end

    for (genvar i = 0; i < WATCH_CNT; i++) begin : g_fields
        assign watch_en[i]  = sense_q[SENSE_EN_LSB + i];
        assign all_edges[i] = sense_q[SENSE_ALL_LSB + i];
        assign rise_only[i] = sense_q[SENSE_RISE_LSB + i];
    end

    assign rts_bit  = drive_q[DRV_RTS];
    assign dtr_bit  = drive_q[DRV_DTR];
    assign loop_bit = drive_q[DRV_LOOP];

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_LINES: begin
                rdata[LINE_CNT-1:0]                       = levels;
                rdata[LINE_CHG_LSB +: WATCH_CNT]          = pend;
            end
            SEL_SENSE: rdata[SENSE_W-1:0] = sense_q;
            SEL_DRIVE: rdata[DRV_W-1:0]   = drive_q;
            SEL_NONE:  rdata              = '0;
            default:   rdata              = '0;
        endcase
    end

endmodule

// File: rtl/modem_line_watch.sv
module modem_line_watch
    import mlw_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cts_i,
    input  logic              dcd_i,
    input  logic              ri_i,
    input  logic              dsr_i,
    output logic              rts_n_o,
    output logic              dtr_n_o,
    output logic              loop_en_o,
    output logic              line_chg_o
);

    logic [LINE_CNT-1:0]  pins_raw;
    logic [LINE_CNT-1:0]  lvl_s;
    logic [WATCH_CNT-1:0] qual_w, pend_w;
    logic [WATCH_CNT-1:0] watch_en_w, all_edges_w, rise_only_w;
    logic                 rts_bit, dtr_bit, loop_bit;
    logic                 clr_rd;

    always_comb begin
        pins_raw          = '0;
        pins_raw[IDX_CTS] = cts_i;
        pins_raw[IDX_DCD] = dcd_i;
        pins_raw[IDX_RI]  = ri_i;
        pins_raw[IDX_DSR] = dsr_i;
    end

    mlw_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (lvl_s)
    );

    assign clr_rd = bus_rd && (reg_sel_e'(bus_addr) == SEL_LINES);

    for (genvar i = 0; i < WATCH_CNT; i++) begin : g_track
        mlw_chg_track i_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (lvl_s[i]),
            .watch_en  (watch_en_w[i]),
            .all_edges (all_edges_w[i]),
            .rise_only (rise_only_w[i]),
            .clr       (clr_rd),
            .qualify   (qual_w[i]),
            .pending   (pend_w[i])
        );
    end

    mlw_regs #(.DATA_W(DATA_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .levels    (lvl_s),
        .pend      (pend_w),
        .rdata     (bus_rdata),
        .watch_en  (watch_en_w),
        .all_edges (all_edges_w),
        .rise_only (rise_only_w),
        .rts_bit   (rts_bit),
        .dtr_bit   (dtr_bit),
        .loop_bit  (loop_bit)
    );

    assign rts_n_o    = ~rts_bit;
    assign dtr_n_o    = ~dtr_bit;
    assign loop_en_o  = loop_bit;
    assign line_chg_o = |(pend_w & watch_en_w);

endmodule

module modem_line_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic [2:0] wdata_lo,
    input logic       rts_n_o,
    input logic       dtr_n_o,
    input logic       loop_en_o,
    input logic       line_chg_o,
    input logic [1:0] qual_w,
    input logic [1:0] pend_w,
    input logic [1:0] watch_en_w
);

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_w & ~$past(pend_w) & ~$past(qual_w)) == 2'b00)); // R2

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_w & ~$past(pend_w) & ~$past(watch_en_w)) == 2'b00)); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |=> ((pend_w & ~$past(qual_w)) == 2'b00)); // R5

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_w != 2'b00) |=> ((pend_w & $past(qual_w)) == $past(qual_w))); // R6

    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_chg_o |-> (pend_w != 2'b00)); // R7

    AST_DRIVE_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=>
            (rts_n_o == !$past(wdata_lo[0]) && dtr_n_o == !$past(wdata_lo[1]))); // R8

    AST_LOOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> (loop_en_o == $past(wdata_lo[2]))); // R9

endmodule

bind modem_line_watch modem_line_watch_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .wdata_lo   (bus_wdata[2:0]),
    .rts_n_o    (rts_n_o),
    .dtr_n_o    (dtr_n_o),
    .loop_en_o  (loop_en_o),
    .line_chg_o (line_chg_o),
    .qual_w     (qual_w),
    .pend_w     (pend_w),
    .watch_en_w (watch_en_w)
);

// File: tb/test_modem_line_watch.sv
module test_modem_line_watch;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_wr, bus_rd;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [3:0] pins;
    logic       rts_n_o, dtr_n_o, loop_en_o, line_chg_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    // bench model state
    logic [3:0] m_s1, m_s2;
    logic [1:0] m_prv, m_pend;
    logic [5:0] m_sense;
    logic [2:0] m_drive;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_line_watch i_modem_line_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cts_i      (pins[0]),
        .dcd_i      (pins[1]),
        .ri_i       (pins[2]),
        .dsr_i      (pins[3]),
        .rts_n_o    (rts_n_o),
        .dtr_n_o    (dtr_n_o),
        .loop_en_o  (loop_en_o),
        .line_chg_o (line_chg_o)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {2'b00, m_pend, m_s2};
            2'd1:    return {2'b00, m_sense};
            2'd2:    return {5'b0, m_drive};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_flag();
        return |(m_pend & m_sense[1:0]);
    endfunction

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_prv = '0; m_pend = '0;
        m_sense = '0; m_drive = '0;
    endtask

    task automatic model_step();
        logic clr;
        clr = bus_rd && (bus_addr == 2'd0);
        for (int i = 0; i < 2; i++) begin
            logic ed, up, sel, q;
            ed  = m_s2[i] ^ m_prv[i];
            up  = m_s2[i] & ~m_prv[i];
            sel = m_sense[2+i] ? ed : (m_sense[4+i] ? up : (ed & ~up));
            q   = m_sense[i] & sel;
            m_pend[i] = q | (m_pend[i] & ~clr);
        end
        m_prv = m_s2[1:0];
        m_s2  = m_s1;
        m_s1  = pins;
        if (bus_wr && bus_addr == 2'd1) m_sense = bus_wdata[5:0];
        if (bus_wr && bus_addr == 2'd2) m_drive = bus_wdata[2:0];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare full output set against the model, then advance one clock
    task automatic cyc(input string tag);
        #1;
        check(tag, {bus_rdata, line_chg_o, rts_n_o, dtr_n_o, loop_en_o},
              {exp_read(bus_addr), exp_flag(), ~m_drive[0], ~m_drive[1], m_drive[2]});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input string tag);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc(tag);
        idle();
    endtask

    task automatic clear_read(input string tag);
        bus_rd = 1; bus_addr = 2'd0;
        cyc(tag);
        idle();
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd5521));
        rst_n = 0; pins = '0; idle(); model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R11 reset values
        #1;
        check("R11 pins after reset", {rts_n_o, dtr_n_o, loop_en_o, line_chg_o}, 4'b1100);
        bus_addr = 2'd0; cyc("R11 line reg");
        bus_addr = 2'd1; cyc("R11 sense reg");
        bus_addr = 2'd2; cyc("R11 drive reg");
        idle();

        // R10 readback, address 3 zero
        wr_reg(2'd1, 8'hFF, "R10 write");
        bus_addr = 2'd1; #1;
        check("R10 sense readback", bus_rdata, 8'h3F);
        cyc("R10");
        bus_addr = 2'd3; cyc("R10 unused address");
        idle();
        wr_reg(2'd1, 8'h0F, "R2 config all-edges");

        // R8 / R9 drive pins
        wr_reg(2'd2, 8'h05, "R8 write");
        #1;
        check("R8 rts/dtr inverted", {rts_n_o, dtr_n_o}, 2'b01);
        check("R9 loopback bit", loop_en_o, 1'b1);
        wr_reg(2'd2, 8'h02, "R8 rewrite");
        #1;
        check("R8 second pattern", {rts_n_o, dtr_n_o, loop_en_o}, 3'b100);

        // R1 levels after two edges
        pins = 4'b1100;
        cyc("R1 pre");
        #1; check("R1 one edge not yet", bus_rdata[3:0], 4'b0000);
        cyc("R1 pre2");
        #1; check("R1 levels visible", bus_rdata[3:0], 4'b1100);
        run(2, "R1");

        // R2 rising and falling on clear-to-send, R7 flag
        pins[0] = 1; run(3, "R2 rise");
        #1; check("R2 cts rise sets bit 4", bus_rdata[5:4], 2'b01);
        check("R7 flag on", line_chg_o, 1'b1);
        clear_read("R5 read");
        #1; check("R5 cleared", {bus_rdata[5:4], line_chg_o}, 3'b000);
        pins[0] = 0; run(3, "R2 fall");
        #1; check("R2 cts fall sets bit 4", bus_rdata[4], 1'b1);
        pins[1] = 1; run(3, "R2 dcd rise");
        #1; check("R2 dcd sets bit 5", bus_rdata[5:4], 2'b11);
        clear_read("R5 read both");
        #1; check("R5 both cleared", bus_rdata[5:4], 2'b00);

        // R4 single polarity: cts rising only, dcd falling only
        wr_reg(2'd1, 8'h13, "R4 config");
        pins[0] = 1; run(3, "R4 rise");
        #1; check("R4 selected rising sets", bus_rdata[4], 1'b1);
        clear_read("R4 clear");
        pins[0] = 0; run(3, "R4 fall");
        #1; check("R4 falling ignored", bus_rdata[4], 1'b0);
        pins[1] = 0; run(3, "R4 dcd fall");
        #1; check("R4 dcd falling sets", bus_rdata[5], 1'b1);
        clear_read("R4 clear2");

        // R3 masked channel
        wr_reg(2'd1, 8'h0E, "R3 config");
        pins[0] = 1; run(3, "R3");
        pins[0] = 0; run(3, "R3");
        #1; check("R3 masked cts no status", {bus_rdata[4], line_chg_o}, 2'b00);

        // R6 edge in the same cycle as clearing read
        wr_reg(2'd1, 8'h0F, "R6 config");
        pins[1] = 1; run(3, "R6 setup");
        pins[1] = 0; cyc("R6 stage1"); cyc("R6 stage2");
        bus_rd = 1; bus_addr = 2'd0; cyc("R6 coincident read");
        idle();
        #1; check("R6 status survives", bus_rdata[5], 1'b1);

        // R7 disabling drops the flag but keeps the bit
        wr_reg(2'd1, 8'h0D, "R7 disable dcd");
        #1; check("R7 flag dropped, bit kept", {line_chg_o, bus_rdata[5]}, 2'b01);
        clear_read("R7 clear");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) pins = pins ^ r[7:4];
            bus_rd    = (r[10:8] == 3'd0);
            bus_wr    = (r[14:11] == 4'd0);
            bus_addr  = bus_wr ? (r[15] ? 2'd1 : 2'd2) : r[17:16];
            bus_wdata = r[31:24];
            cyc("R2/R4/R5/R6/R7 random");
        end
        idle();

        done = 1;
        finish_run();
    end

endmodule